// File: doc/BRIEF.md
# Line-Doubled Monochrome Scanline Serializer

This block turns a packed one-bit-per-pixel image held in an external memory into a serial pixel stream for a raster display, one bit per pixel clock. Each stored image row is shown on two consecutive display lines, so a framebuffer of half the display height fills the whole active area. An external timing generator supplies three signals: a per-line strobe that comes early in the line, a scanout strobe that marks where active video starts, and the index of the current display line.

When a line strobe arrives on an active line, the block captures the current row address and starts prefetching that row's first word through a simple synchronous read port. It then waits for the scanout strobe. It shifts every halfword out least significant bit first and fetches the following word while the current one is draining, so the stream has no gaps. After the stored pixels, one zero halfword is appended so that the line always ends low. During vertical blanking, the row pointer returns to the framebuffer base.

Top module: `lds_scanline_shifter`

## Requirements
- R1: Pixels are packed 16 to a word. Bit b of a word is the pixel at position b within that word's group of 16, so bit 0 is sent first.
- R2: The pixel at position n of a line (n counted from 0) appears on `pix_out` in the (n+1)-th cycle after the clock edge that samples `start_strobe`. The line's pixels follow each other every cycle with no gap.
- R3: A line lasts ROW_HW = (WIDTH_PX/8 + 2)/2 halfwords, that is ROW_HW*16 cycles. The first WIDTH_PX/16 halfwords come from memory. The remaining halfword is all zeros, and no read is issued for it.
- R4: A line is active when VACT_FIRST <= `line_idx` < VACT_FIRST+VACT_LINES. A line strobe on any other line returns the row pointer to BASE_ADDR, and a scanout strobe on such a line leaves `pix_out` at 0.
- R5: The row pointer advances by STRIDE_WORDS after each active line whose offset (`line_idx` - VACT_FIRST) is odd. Display lines 2k and 2k+1 of the active area therefore both show stored row k, read from BASE_ADDR + k*STRIDE_WORDS.
- R6: `pix_out` is 0 after reset, before the first scanout strobe, and in every cycle after a line's last halfword.
- R7: The read port has a latency of one cycle: data for a read with `rd_en` high is presented on `rd_data` in the next cycle. The scanout strobe must come at least 4 cycles after the line strobe.
- R8: A scanout strobe that arrives while a line is being shifted is ignored and does not disturb that line's output.
- R9: The reads for an active line go to row_base, row_base+1, … in that order, one read per stored word, each issued only after the line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | Early per-line pulse from the timing generator |
| start_strobe | input | 1 | Pulse marking the start of active video in the line |
| line_idx | input | LINE_W | Current display line number |
| rd_en | output | 1 | Framebuffer read request |
| rd_addr | output | ADDR_W | Framebuffer word address |
| rd_data | input | 16 | Read data, valid the cycle after `rd_en` |
| pix_out | output | 1 | Serial pixel output |

## Verification
On every cycle, the embedded properties check four things. The row pointer only ever steps by one stride or jumps back to the base. Every read falls inside the current row's stored words. The prefetch buffer is always full when the serializer takes a new word. A scanout strobe in mid-line never disturbs the bit counter. Only the bench's frame scenarios can show the remaining behaviour: the pixel-exact contents of each line, LSB-first ordering, the doubling of each row across two lines, the zero tail halfword, the pointer reset across vertical blanking, and the per-line count and order of reads.

// File: rtl/lds_pkg.sv
package lds_pkg;
   localparam int unsigned HW_BITS = 16;

   // halfwords sent for one row, including the trailing zero halfword
   function automatic int unsigned row_halfwords(input int unsigned width_px);
      return (width_px / 8 + 2) / 2;
   endfunction

   // halfwords that actually hold stored pixels
   function automatic int unsigned stored_words(input int unsigned width_px);
      return width_px / HW_BITS;
   endfunction
endpackage

// File: rtl/lds_row_tracker.sv
module lds_row_tracker #(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned LINE_W       = 10,
   parameter int unsigned BASE_ADDR    = 0,
   parameter int unsigned STRIDE_WORDS = 20,
   parameter int unsigned VACT_FIRST   = 16,
   parameter int unsigned VACT_LINES   = 480
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_strobe,
   input  logic [LINE_W-1:0] line_idx,
   output logic              load_go,
   output logic [ADDR_W-1:0] line_base
);
   localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(VACT_FIRST);
   localparam logic [LINE_W-1:0] END_L   = LINE_W'(VACT_FIRST + VACT_LINES);
   localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(STRIDE_WORDS);

   logic [ADDR_W-1:0] row_ptr;
   logic              in_active;
   logic              odd_off;

   assign in_active = (line_idx >= FIRST_L) && (line_idx < END_L);
   assign odd_off   = line_idx[0] ^ FIRST_L[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_ptr   <= BASE_A;
         line_base <= BASE_A;
         load_go   <= 1'b0;
      end else begin
         load_go <= 1'b0;
         if (line_strobe) begin
            if (in_active) begin
               line_base <= row_ptr;
               load_go   <= 1'b1;
               if (odd_off) row_ptr <= row_ptr + STEP_A;
            end else begin
               row_ptr <= BASE_A;
            end
         end
      end
   end

   // pointer moves only by one stride or back to the base
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (row_ptr != $past(row_ptr)) |-> ((row_ptr == BASE_A) || (row_ptr == $past(row_ptr) + STEP_A)));
endmodule

// File: rtl/lds_word_prefetch.sv
module lds_word_prefetch #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_WORDS = 20,
   parameter int unsigned ROW_HW     = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_go,
   input  logic [ADDR_W-1:0] line_base,
   input  logic              take,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [15:0]       rd_data,
   output logic [15:0]       buf_word,
   output logic              buf_valid
);
   localparam int unsigned CNT_W = $clog2(ROW_HW + 1);
   localparam logic [CNT_W-1:0] ROW_HW_C = CNT_W'(ROW_HW);
   localparam logic [CNT_W-1:0] DATA_C   = CNT_W'(DATA_WORDS);

   logic [CNT_W-1:0]  idx;
   logic [ADDR_W-1:0] base_q;
   logic              pend;
   logic              more_words;
   logic              data_phase;

   assign more_words = idx < ROW_HW_C;
   assign data_phase = idx < DATA_C;
   assign rd_en      = !load_go && !buf_valid && !pend && data_phase;
   assign rd_addr    = base_q + ADDR_W'(idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx       <= ROW_HW_C;
         base_q    <= '0;
         pend      <= 1'b0;
         buf_valid <= 1'b0;
         buf_word  <= '0;
      end else if (load_go) begin
         base_q    <= line_base;
         idx       <= '0;
         pend      <= 1'b0;
         buf_valid <= 1'b0;
      end else begin
         if (pend) begin
            buf_word  <= rd_data;
            buf_valid <= 1'b1;
            pend      <= 1'b0;
         end else if (!buf_valid && more_words) begin
            idx <= idx + 1'b1;
            if (data_phase) begin
               pend <= 1'b1;
            end else begin
               buf_word  <= '0;
               buf_valid <= 1'b1;
            end
         end
         if (take) buf_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/lds_bit_serializer.sv
module lds_bit_serializer #(
   parameter int unsigned ROW_HW = 21
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        line_strobe,
   input  logic        load_go,
   input  logic        start_strobe,
   input  logic [15:0] buf_word,
   output logic        take,
   output logic        pix_out
);
   import lds_pkg::*;
   localparam int unsigned CNT_W = $clog2(ROW_HW + 1);
   localparam int unsigned BIT_W = $clog2(HW_BITS);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(HW_BITS - 1);
   localparam logic [CNT_W-1:0] HW_LAST  = CNT_W'(ROW_HW - 1);

   logic [15:0]      shreg;
   logic [BIT_W-1:0] bit_q;
   logic [CNT_W-1:0] hw_left;
   logic             shifting;
   logic             ready;
   logic             launch;
   logic             word_end;
   logic             reload;

   assign launch   = start_strobe && ready && !shifting;
   assign word_end = shifting && (bit_q == LAST_BIT);
   assign reload   = word_end && (hw_left != '0);
   assign take     = launch || reload;
   assign pix_out  = shifting & shreg[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         bit_q    <= '0;
         hw_left  <= '0;
         shifting <= 1'b0;
         ready    <= 1'b0;
      end else begin
         if (line_strobe)  ready <= 1'b0;
         else if (load_go) ready <= 1'b1;
         if (launch) begin
            shreg    <= buf_word;
            bit_q    <= '0;
            hw_left  <= HW_LAST;
            shifting <= 1'b1;
            ready    <= 1'b0;
         end else if (shifting) begin
            if (word_end) begin
               if (hw_left != '0) begin
                  shreg   <= buf_word;
                  bit_q   <= '0;
                  hw_left <= hw_left - 1'b1;
               end else begin
                  shifting <= 1'b0;
               end
            end else begin
               shreg <= shreg >> 1;
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   // a scanout strobe in mid-word leaves the bit count running on
   assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_strobe && shifting && (bit_q != LAST_BIT)) |=> (shifting && (bit_q == $past(bit_q) + 1'b1)));
endmodule

// File: rtl/lds_scanline_shifter.sv
module lds_scanline_shifter #(
   parameter int unsigned WIDTH_PX     = 320,
   parameter int unsigned STRIDE_WORDS = 20,
   parameter int unsigned BASE_ADDR    = 0,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned LINE_W       = 10,
   parameter int unsigned VACT_FIRST   = 16,
   parameter int unsigned VACT_LINES   = 480
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_strobe,
   input  logic              start_strobe,
   input  logic [LINE_W-1:0] line_idx,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [15:0]       rd_data,
   output logic              pix_out
);
   import lds_pkg::*;
   localparam int unsigned ROW_HW     = row_halfwords(WIDTH_PX);
   localparam int unsigned DATA_WORDS = stored_words(WIDTH_PX);

   generate
      if ((WIDTH_PX == 0) || (WIDTH_PX % HW_BITS != 0)) begin : g_bad_width
         $error("WIDTH_PX must be a nonzero multiple of 16");
      end
      if (STRIDE_WORDS < DATA_WORDS) begin : g_bad_stride
         $error("STRIDE_WORDS smaller than one stored row");
      end
      if (VACT_FIRST + VACT_LINES > (1 << LINE_W)) begin : g_bad_lines
         $error("active line range does not fit LINE_W");
      end
   endgenerate

   logic              load_go;
   logic [ADDR_W-1:0] line_base;
   logic              take;
   logic [15:0]       buf_word;
   logic              buf_valid;

   lds_row_tracker #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BASE_ADDR(BASE_ADDR),
      .STRIDE_WORDS(STRIDE_WORDS), .VACT_FIRST(VACT_FIRST), .VACT_LINES(VACT_LINES)
   ) row_i (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_idx(line_idx),
      .load_go(load_go), .line_base(line_base)
   );

   lds_word_prefetch #(
      .ADDR_W(ADDR_W), .DATA_WORDS(DATA_WORDS), .ROW_HW(ROW_HW)
   ) fetch_i (
      .clk(clk), .rst_n(rst_n), .load_go(load_go), .line_base(line_base),
      .take(take), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .buf_word(buf_word), .buf_valid(buf_valid)
   );

   lds_bit_serializer #(
      .ROW_HW(ROW_HW)
   ) ser_i (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .load_go(load_go),
      .start_strobe(start_strobe), .buf_word(buf_word), .take(take), .pix_out(pix_out)
   );

   // the serializer never takes an empty prefetch buffer
   assert_take_fed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> buf_valid);

   // reads stay inside the stored words of the current row
   assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> ((rd_addr >= line_base) && (rd_addr < line_base + ADDR_W'(DATA_WORDS))));
endmodule

// File: tb/lds_scanline_shifter_tb_top.sv
module lds_scanline_shifter_tb_top;
   localparam int unsigned WPX    = 64;
   localparam int unsigned STRIDE = 6;
   localparam int unsigned BASE   = 8;
   localparam int unsigned FIRST  = 3;
   localparam int unsigned NLINES = 6;
   localparam int unsigned DWORDS = WPX / 16;
   localparam int unsigned NBITS  = ((WPX / 8 + 2) / 2) * 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_strobe = 1'b0;
   logic       start_strobe = 1'b0;
   logic [5:0] line_idx = '0;
   logic       rd_en;
   logic [7:0] rd_addr;
   logic [15:0] rd_data;
   logic       pix_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lds_scanline_shifter #(
      .WIDTH_PX(WPX), .STRIDE_WORDS(STRIDE), .BASE_ADDR(BASE), .ADDR_W(8),
      .LINE_W(6), .VACT_FIRST(FIRST), .VACT_LINES(NLINES)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .start_strobe(start_strobe),
      .line_idx(line_idx), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .pix_out(pix_out)
   );

   function automatic logic [15:0] mem_val(input int a);
      return 16'((a * 40503 + 4919) ^ (a << 9));
   endfunction

   // framebuffer model with one cycle read latency (R7)
   always @(posedge clk) if (rd_en) rd_data <= mem_val(int'(rd_addr));

   int rd_cnt = 0;
   int rd_log [8];
   always @(posedge clk) begin
      if (line_strobe) rd_cnt <= 0;
      else if (rd_en) begin
         if (rd_cnt < 8) rd_log[rd_cnt] <= int'(rd_addr);
         rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one display line: strobe, wait, scanout, compare every pixel
   task automatic run_line(input int idx, input bit act, input int row, input bit restart);
      int errs = 0;
      int first_bad = -1;
      @(negedge clk);
      line_strobe = 1'b1; line_idx = 6'(idx);
      @(negedge clk);
      line_strobe = 1'b0;
      repeat (6) @(negedge clk);
      start_strobe = 1'b1;
      @(negedge clk);
      start_strobe = 1'b0;
      for (int n = 0; n < int'(NBITS); n++) begin
         logic e;
         int w;
         w = n / 16;
         e = (act && w < int'(DWORDS)) ? mem_val(int'(BASE) + row * int'(STRIDE) + w)[n % 16] : 1'b0;
         if (pix_out !== e) begin
            errs++;
            if (first_bad < 0) first_bad = n;
         end
         if (restart && n == 21) start_strobe = 1'b1;
         else start_strobe = 1'b0;
         @(negedge clk);
      end
      start_strobe = 1'b0;
      // R1 R2 R3 R5 R8: whole line pixel-exact, LSB first, doubled rows, zero tail
      chk(errs == 0, act ? "R1/R2/R5 line pixels" : "R4 blank line pixels", errs, 0);
      if (first_bad >= 0) $display("  line %0d first mismatch at pixel %0d", idx, first_bad);
      chk(pix_out == 1'b0, "R6 idle after line", int'(pix_out), 0);
      // R3 R9: reads only for stored words, in address order
      chk(rd_cnt == (act ? int'(DWORDS) : 0), "R3 read count", rd_cnt, act ? int'(DWORDS) : 0);
      if (act) begin
         for (int k = 0; k < int'(DWORDS); k++)
            chk(rd_log[k] == int'(BASE) + row * int'(STRIDE) + k, "R9 read address",
                rd_log[k], int'(BASE) + row * int'(STRIDE) + k);
      end
      repeat (3) @(negedge clk);
   endtask

   typedef struct packed {
      logic [5:0] idx;
      logic       act;
      logic [3:0] row;
      logic       restart;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{6'd0,  1'b0, 4'd0, 1'b0},
      '{6'd1,  1'b0, 4'd0, 1'b0},
      '{6'd2,  1'b0, 4'd0, 1'b0},
      '{6'd3,  1'b1, 4'd0, 1'b0},
      '{6'd4,  1'b1, 4'd0, 1'b1},
      '{6'd5,  1'b1, 4'd1, 1'b0},
      '{6'd6,  1'b1, 4'd1, 1'b0},
      '{6'd7,  1'b1, 4'd2, 1'b1},
      '{6'd8,  1'b1, 4'd2, 1'b0},
      '{6'd9,  1'b0, 4'd0, 1'b0},
      '{6'd10, 1'b0, 4'd0, 1'b0},
      '{6'd3,  1'b1, 4'd0, 1'b0},
      '{6'd4,  1'b1, 4'd0, 1'b0},
      '{6'd5,  1'b1, 4'd1, 1'b0}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      chk(pix_out == 1'b0, "R6 pix in reset", int'(pix_out), 0);
      chk(rd_en == 1'b0, "R7 no read in reset", int'(rd_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R4/R6: scanout strobe with no line loaded produces nothing
      begin
         int hits = 0;
         start_strobe = 1'b1;
         @(negedge clk);
         start_strobe = 1'b0;
         for (int n = 0; n < 40; n++) begin
            if (pix_out !== 1'b0 || rd_en !== 1'b0) hits++;
            @(negedge clk);
         end
         chk(hits == 0, "R4 start without line", hits, 0);
      end
      // frame table: blank lines, doubled rows, mid-line restarts, wrap to base
      for (int v = 0; v < NV; v++)
         run_line(int'(VECS[v].idx), VECS[v].act, int'(VECS[v].row), VECS[v].restart);
      // R6: reset in mid-line forces output low
      @(negedge clk);
      line_strobe = 1'b1; line_idx = 6'(FIRST);
      @(negedge clk);
      line_strobe = 1'b0;
      repeat (6) @(negedge clk);
      start_strobe = 1'b1;
      @(negedge clk);
      start_strobe = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(pix_out == 1'b0, "R6 pix after mid-line reset", int'(pix_out), 0);
      rst_n = 1'b1;
      // R5: after reset the pointer is at base again
      run_line(int'(FIRST), 1'b1, 0, 1'b0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule